// File: doc/BRIEF.md
# Round-Robin Multichannel Serial ADC Sampler

This block is a small serial master that keeps reading a bank of external analog-to-digital converters without software help. It selects one channel at a time, clocks a fixed 16-bit frame out of the selected converter over a single shared data input, and stores the result in that channel's own register. It then moves on to the next channel and wraps around after the last one in use. The host reads any channel's latest result and its valid flag through a plain combinational read port.

A two-bit protocol input sets the sample width and the channel limit. Code 0 is a quad-channel part with 12-bit samples. In that mode one device serves four channels, and the low two select lines drive its channel inputs directly. Code 1 takes 15-bit samples and code 2 takes 16-bit samples; code 3 behaves like code 2. Codes 1 to 3 use one converter per channel, up to eight, and the select lines carry a binary index meant for an external 3-to-8 active-low decoder. The serial clock is the system clock divided by a programmable value. The scan runs while the enable input is high.

Top module: `rr_adc_sampler`

## Requirements
- R1: After reset `cs_n` and `sclk` are 1, and every channel reads back a result of 0 with its valid flag at 0.
- R2: During a frame `cs_n` stays low for exactly 32*(`clk_div`+1) clock cycles. Within that time `sclk` alternates a low phase and a high phase of `clk_div`+1 cycles each, starting low, which gives exactly 16 rising edges per frame. Outside a frame `sclk` is held high.
- R3: `sdi` is sampled on each rising edge of `sclk`, most significant bit first. The stored result keeps only the last W bits received, right-aligned, with the upper bits at zero. W is 12 for protocol code 0, 15 for code 1, and 16 for codes 2 and 3.
- R4: The number of channels scanned is `ch_count`, with two adjustments: a value of 0 is read as 1, and the count is limited to 8, or to 4 when the protocol code is 0.
- R5: Each run started by raising `enable` from idle begins at channel 0. Channels are then visited in ascending order, and the scan returns to channel 0 after the last channel in use.
- R6: `cs_sel` carries the binary index of the channel being read and stays constant while `cs_n` is low. With protocol code 0, bit 2 stays 0 and bits 1:0 select the channel directly.
- R7: Between two frames `cs_n` stays high for at least 4*(`clk_div`+1) clock cycles, which is two serial clock periods.
- R8: A channel's result and its valid flag change only at the clock edge that ends that channel's frame. Valid flags are never cleared except by reset. Channels outside the active count keep their contents.
- R9: `rd_data` and `rd_valid` show the result and valid flag of the channel named by `rd_addr`, with no register in the path.
- R10: Clearing `enable` during a frame lets that frame finish and be stored. No further frame starts after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the scan while high |
| mode | input | 2 | Protocol code: 0 = 12-bit quad, 1 = 15-bit, 2 or 3 = 16-bit |
| ch_count | input | 4 | Requested number of channels to scan |
| clk_div | input | 8 | Serial clock half period minus one, in clock cycles |
| sclk | output | 1 | Serial clock to the converters |
| cs_n | output | 1 | Active-low frame strobe |
| cs_sel | output | 3 | Channel index of the current frame |
| sdi | input | 1 | Shared serial data from the converters |
| rd_addr | input | 3 | Channel to read |
| rd_data | output | 16 | Result of the addressed channel |
| rd_valid | output | 1 | Valid flag of the addressed channel |
| valid_flags | output | 8 | Valid flags of all channels |

## Verification
The bench models the converters. Each channel gets its own random word, and the model shifts the word out on `sdi` following `cs_sel` and the `sclk` edges. Every frame is timed from the ports.

The stimulus targets the corner cases of the channel count: a count of zero, a count above the quad limit in protocol code 0, and a count above eight. A design that mishandles these either scans channels it should skip or overwrites registers that should keep earlier values.

Each protocol code is checked against its width mask, so a mask applied at the wrong end of the word, or a missing code 3 case, shows up as wrong upper or lower bits. Dropping `enable` in the middle of a frame tests the stop rule: a design that stops too early loses the last result, and one that stops too late runs an extra frame.

// File: rtl/rr_adc_pkg.sv
package rr_adc_pkg;

   localparam int FRAME_LEN   = 16;
   localparam int GAP_PHASES  = 4;
   localparam logic [1:0] PROTO_QUAD12 = 2'd0;
   localparam logic [1:0] PROTO_W15    = 2'd1;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_XFER = 2'd1,
      ST_GAP  = 2'd2
   } seq_state_e;

   function automatic logic [FRAME_LEN-1:0] proto_mask(input logic [1:0] code);
      case (code)
         PROTO_QUAD12: return 16'h0FFF;
         PROTO_W15:    return 16'h7FFF;
         default:      return 16'hFFFF;
      endcase
   endfunction

endpackage

// File: rtl/rr_adc_tick.sv
module rr_adc_tick #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   logic [DIV_W-1:0] cnt_q;

   assign tick = run && (cnt_q == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (!run || tick)  cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/rr_adc_chan_seq.sv
module rr_adc_chan_seq #(
   parameter int N_CH  = 8,
   parameter int SEL_W = 3,
   parameter int CNT_W = 4
) (
   input  logic [1:0]       mode,
   input  logic [CNT_W-1:0] ch_count,
   input  logic [SEL_W-1:0] cur_ch,
   output logic [CNT_W-1:0] n_eff,
   output logic [SEL_W-1:0] next_ch
);
   import rr_adc_pkg::*;

   localparam int QUAD_LIM = (N_CH < 4) ? N_CH : 4;
   localparam logic [CNT_W-1:0] CAP_FULL = CNT_W'(N_CH);
   localparam logic [CNT_W-1:0] CAP_QUAD = CNT_W'(QUAD_LIM);

   if (CNT_W != SEL_W + 1) begin : g_bad_width
      $error("rr_adc_chan_seq: CNT_W must be SEL_W+1");
   end

   logic [CNT_W-1:0] cap, req, inc;

   always_comb begin
      cap   = (mode == PROTO_QUAD12) ? CAP_QUAD : CAP_FULL;
      req   = (ch_count == '0) ? CNT_W'(1) : ch_count;
      n_eff = (req > cap) ? cap : req;
      inc   = {1'b0, cur_ch} + CNT_W'(1);
      next_ch = (inc >= n_eff) ? '0 : inc[SEL_W-1:0];
   end

endmodule

// File: rtl/rr_adc_result_bank.sv
module rr_adc_result_bank #(
   parameter int N_CH   = 8,
   parameter int DATA_W = 16,
   parameter int SEL_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_ch,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [SEL_W-1:0]  rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic [N_CH-1:0]   valid_flags
);

   localparam int DEPTH = 1 << SEL_W;

   logic [DATA_W-1:0] words [DEPTH];
   logic [DEPTH-1:0]  vld_all;

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      if (g < N_CH) begin : g_live
         logic [DATA_W-1:0] word_q;
         logic              vld_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               word_q <= '0;
               vld_q  <= 1'b0;
            end else if (wr_en && (wr_ch == SEL_W'(g))) begin
               word_q <= wr_data;
               vld_q  <= 1'b1;
            end
         end
         assign words[g]   = word_q;
         assign vld_all[g] = vld_q;
      end else begin : g_empty
         assign words[g]   = '0;
         assign vld_all[g] = 1'b0;
      end
   end

   assign valid_flags = vld_all[N_CH-1:0];
   assign rd_data     = words[rd_addr];
   assign rd_valid    = vld_all[rd_addr];

endmodule

// File: rtl/rr_adc_sampler.sv
module rr_adc_sampler #(
   parameter int N_CH  = 8,
   parameter int DIV_W = 8,
   localparam int SEL_W = (N_CH > 1) ? $clog2(N_CH) : 1,
   localparam int CNT_W = SEL_W + 1,
   localparam int DATA_W = rr_adc_pkg::FRAME_LEN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [1:0]        mode,
   input  logic [CNT_W-1:0]  ch_count,
   input  logic [DIV_W-1:0]  clk_div,
   output logic              sclk,
   output logic              cs_n,
   output logic [SEL_W-1:0]  cs_sel,
   input  logic              sdi,
   input  logic [SEL_W-1:0]  rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic [N_CH-1:0]   valid_flags
);
   import rr_adc_pkg::*;

   localparam int PH_W  = $clog2(2 * FRAME_LEN);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(2 * FRAME_LEN - 1);
   localparam int GAP_W = $clog2(GAP_PHASES);
   localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_PHASES - 1);

   if (N_CH < 2 || N_CH > 8) begin : g_bad_nch
      $error("rr_adc_sampler: N_CH must lie in 2..8");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("rr_adc_sampler: DIV_W must be at least 1");
   end

   seq_state_e         state_q;
   logic [PH_W-1:0]    ph_q;
   logic [GAP_W-1:0]   gap_q;
   logic [SEL_W-1:0]   ch_q;
   logic [DATA_W-1:0]  sr_q;
   logic               tick;
   logic               wr_en;
   logic [CNT_W-1:0]   n_eff;
   logic [SEL_W-1:0]   next_ch;

   rr_adc_tick #(.DIV_W(DIV_W)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (state_q != ST_IDLE),
      .div  (clk_div),
      .tick (tick)
   );

   rr_adc_chan_seq #(.N_CH(N_CH), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_seq (
      .mode    (mode),
      .ch_count(ch_count),
      .cur_ch  (ch_q),
      .n_eff   (n_eff),
      .next_ch (next_ch)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ph_q    <= '0;
         gap_q   <= '0;
         ch_q    <= '0;
         sr_q    <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (enable) begin
                  state_q <= ST_XFER;
                  ph_q    <= '0;
                  ch_q    <= '0;
               end
            end
            ST_XFER: begin
               if (tick) begin
                  ph_q <= ph_q + 1'b1;
                  if (!ph_q[0]) sr_q <= {sr_q[DATA_W-2:0], sdi};
                  if (ph_q == PH_LAST) begin
                     state_q <= ST_GAP;
                     gap_q   <= '0;
                  end
               end
            end
            ST_GAP: begin
               if (tick) begin
                  gap_q <= gap_q + 1'b1;
                  if (gap_q == GAP_LAST) begin
                     if (enable) begin
                        state_q <= ST_XFER;
                        ph_q    <= '0;
                        ch_q    <= next_ch;
                     end else begin
                        state_q <= ST_IDLE;
                     end
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign wr_en  = (state_q == ST_XFER) && tick && (ph_q == PH_LAST);
   assign sclk   = (state_q == ST_XFER) ? ph_q[0] : 1'b1;
   assign cs_n   = (state_q != ST_XFER);
   assign cs_sel = ch_q;

   rr_adc_result_bank #(.N_CH(N_CH), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_ch      (ch_q),
      .wr_data    (sr_q & proto_mask(mode)),
      .rd_addr    (rd_addr),
      .rd_data    (rd_data),
      .rd_valid   (rd_valid),
      .valid_flags(valid_flags)
   );

endmodule

// File: rtl/rr_adc_sampler_chk.sv
module rr_adc_sampler_chk #(
   parameter int N_CH   = 8,
   parameter int SEL_W  = 3,
   parameter int CNT_W  = 4,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sclk,
   input logic              cs_n,
   input logic [SEL_W-1:0]  cs_sel,
   input logic [N_CH-1:0]   valid_flags,
   input logic              wr_en,
   input logic [CNT_W-1:0]  n_eff,
   input logic [SEL_W-1:0]  rd_addr,
   input logic [DATA_W-1:0] rd_data
);

   // Serial clock idles high whenever no frame is active
   assert_idle_clk_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> sclk);

   // Channel index held for the whole frame
   assert_sel_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && $past(!cs_n)) |-> $stable(cs_sel));

   // Only channels inside the effective count are selected
   assert_sel_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> ({1'b0, cs_sel} < n_eff));

   // Valid flags never fall outside reset
   assert_valid_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((valid_flags & $past(valid_flags)) == $past(valid_flags)));

   // Result writes happen only at the close of a frame
   assert_write_in_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !cs_n);
   assert_write_ends_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> cs_n);

   // Read data holds when nothing was written and the address is unchanged
   assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!wr_en) && $stable(rd_addr)) |-> $stable(rd_data));

endmodule

bind rr_adc_sampler rr_adc_sampler_chk #(
   .N_CH(N_CH), .SEL_W(SEL_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sclk       (sclk),
   .cs_n       (cs_n),
   .cs_sel     (cs_sel),
   .valid_flags(valid_flags),
   .wr_en      (wr_en),
   .n_eff      (n_eff),
   .rd_addr    (rd_addr),
   .rd_data    (rd_data)
);

// File: tb/sim_rr_adc_sampler.sv
module sim_rr_adc_sampler;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic [1:0]  mode = 2'd0;
   logic [3:0]  ch_count = 4'd1;
   logic [7:0]  clk_div = 8'd0;
   logic        sclk, cs_n;
   logic [2:0]  cs_sel;
   logic        sdi;
   logic [2:0]  rd_addr = 3'd0;
   logic [15:0] rd_data;
   logic        rd_valid;
   logic [7:0]  valid_flags;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   logic [15:0] word    [8];
   logic [15:0] exp_res [8];
   logic        exp_val [8];
   int          cur_n, cur_div, exp_next, run_frames;
   int          rises, lowcnt, hicnt;
   logic [2:0]  frame_ch;
   logic        prev_cs, prev_sclk;

   always #(CLK_PERIOD/2) clk = ~clk;

   rr_adc_sampler u0 (
      .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
      .ch_count(ch_count), .clk_div(clk_div), .sclk(sclk), .cs_n(cs_n),
      .cs_sel(cs_sel), .sdi(sdi), .rd_addr(rd_addr), .rd_data(rd_data),
      .rd_valid(rd_valid), .valid_flags(valid_flags)
   );

   task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                      input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   function automatic int eff_count(input logic [1:0] m, input logic [3:0] c);
      int cap = (m == 2'd0) ? 4 : 8;
      int r   = (c == 4'd0) ? 1 : int'(c);
      return (r > cap) ? cap : r;
   endfunction

   function automatic logic [15:0] width_mask(input logic [1:0] m);
      if (m == 2'd0) return 16'h0FFF;
      if (m == 2'd1) return 16'h7FFF;
      return 16'hFFFF;
   endfunction

   // Converter model and frame monitor, stepping on the falling clock edge
   initial begin
      prev_cs = 1'b1; prev_sclk = 1'b1; sdi = 1'b0;
      rises = 0; lowcnt = 0; hicnt = 0; frame_ch = 3'd0;
      exp_next = 0; run_frames = 0; cur_n = 1; cur_div = 0;
      forever begin
         @(negedge clk);
         if (!rst_n) begin
            prev_cs = 1'b1; prev_sclk = 1'b1;
         end else begin
            if (!cs_n) begin
               if (prev_cs) begin
                  chk(cs_sel == 3'(exp_next), "R5 channel order", cs_sel, exp_next);
                  if (run_frames > 0)
                     chk(hicnt >= 4 * (cur_div + 1), "R7 inter-frame gap", hicnt, 4 * (cur_div + 1));
                  frame_ch = cs_sel; rises = 0; lowcnt = 0;
                  exp_next = (exp_next + 1 >= cur_n) ? 0 : exp_next + 1;
               end else begin
                  chk(cs_sel == frame_ch, "R6 select stable", cs_sel, frame_ch);
               end
               if (sclk && !prev_sclk) rises++;
               lowcnt++;
               sdi = (rises < 16) ? word[frame_ch][15 - rises] : 1'b0;
            end else begin
               if (!prev_cs) begin
                  chk(rises == 16, "R2 rising edges per frame", rises, 16);
                  chk(lowcnt == 32 * (cur_div + 1), "R2 frame length", lowcnt, 32 * (cur_div + 1));
                  run_frames++;
                  hicnt = 0;
               end
               hicnt++;
            end
            prev_cs = cs_n; prev_sclk = sclk;
         end
      end
   end

   task automatic read_all();
      for (int a = 0; a < 8; a++) begin
         rd_addr = 3'(a);
         #1;
         chk(rd_data == exp_res[a], "R3 R9 stored result", rd_data, exp_res[a]);
         chk(rd_valid == exp_val[a], "R8 valid flag", rd_valid, exp_val[a]);
      end
   endtask

   task automatic run_case(input logic [1:0] m, input logic [3:0] c, input logic [7:0] d);
      int target;
      @(negedge clk);
      mode = m; ch_count = c; clk_div = d;
      cur_n = eff_count(m, c); cur_div = int'(d);
      for (int i = 0; i < 8; i++) word[i] = 16'($urandom);
      exp_next = 0; run_frames = 0;
      target = 2 * cur_n;
      enable = 1'b1;
      wait (run_frames == target - 1);
      @(negedge cs_n);
      repeat (3) @(negedge clk);
      enable = 1'b0;
      repeat (40 * (cur_div + 1) + 40) @(negedge clk);
      chk(run_frames == target, "R10 stop after current frame", run_frames, target);
      chk(cs_n == 1'b1, "R10 idle after stop", cs_n, 1);
      for (int i = 0; i < cur_n; i++) begin
         exp_res[i] = word[i] & width_mask(m);
         exp_val[i] = 1'b1;
      end
      read_all();
   endtask

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 8; i++) begin
         exp_res[i] = 16'h0; exp_val[i] = 1'b0; word[i] = 16'h0;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cs_n == 1'b1, "R1 cs_n after reset", cs_n, 1);
      chk(sclk == 1'b1, "R1 sclk after reset", sclk, 1);
      chk(valid_flags == 8'h0, "R1 valid flags after reset", valid_flags, 0);
      read_all();

      run_case(2'd0, 4'd7, 8'd0);   // R4 quad limit, R6 low select bits
      run_case(2'd1, 4'd0, 8'd2);   // R4 zero count means one channel
      run_case(2'd2, 4'd8, 8'd1);   // full scan with wrap, R5
      run_case(2'd3, 4'd12, 8'd0);  // R3 code 3 as 16-bit, R4 clamp to 8
      run_case(2'd0, 4'd2, 8'd3);   // R8 channels above count untouched
      for (int k = 0; k < 6; k++)
         run_case(2'($urandom_range(0, 3)), 4'($urandom_range(0, 15)),
                  8'($urandom_range(0, 3)));

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog expired actual=hung expected=finish");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule